// File: doc/BRIEF.md
# Programmable UART baud rate generator

This block makes the bit-rate clock for one direction of an asynchronous serial port. A 4-bit select field picks what advances an 8-bit counter. The choices are:

- the system clock divided by 2^n, for n from 0 to 10;
- rising edges on an external clock pin;
- rising edges on a timer output.

An 8-bit divisor sets the terminal count of the counter. Each time the counter reaches the terminal count it restarts and emits a one-cycle match tick. Every tick toggles a flip-flop, and that flip-flop drives the baud clock output.

Everything runs on the single system clock. The external and timer inputs are synchronized, and their rising edges are turned into count enables. The generator runs only while both the power enable and the direction enable are high.

A two-state controller governs operation:

- **ST_OFF**: the prescaler, the counter and the toggle flip-flop are all held at zero.
- **ST_RUN**: the selected enable advances the counter.

There are two transitions:

- **GO** moves ST_OFF to ST_RUN when both enables are high.
- **STOP** moves ST_RUN to ST_OFF as soon as either enable is low.

Because every stage is cleared in ST_OFF, the first period after a restart is always the same.

Top module: `baud_gen`

## Requirements
- R1: After reset, baud_clk and match_tick are 0.
- R2: For select codes 0 to 10 (code n gives a count enable every 2^n system clocks) and an effective divisor D, baud_clk has a period of 2·D·2^n system clocks and a high time of D·2^n.
- R3: A divisor of 0 to 3 is handled as 4, and div_fault is 1 while it is applied. For divisors of 4 to 255, div_fault is 0 and the divisor is used unchanged.
- R4: match_tick is a one-cycle pulse. baud_clk changes level in exactly the cycles in which match_tick is 1, so there are two ticks per baud period.
- R5: While pwr_en or dir_en is 0, the block stays in ST_OFF, with baud_clk and match_tick at 0. After GO, the first rising edge of baud_clk comes D·2^n clock edges after the first edge that samples the state as ST_RUN.
- R6: Select code 11 counts rising edges of ext_clk. With ext_clk of period P system clocks, the baud_clk period is 2·D·P.
- R7: Select code 12 counts rising edges of tmr_clk. With tmr_clk of period P system clocks, the baud_clk period is 2·D·P.
- R8: Select codes 13 to 15 select no clock. The counter holds, and baud_clk and match_tick do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pwr_en | input | 1 | Power enable for the serial interface |
| dir_en | input | 1 | Transmit or receive direction enable |
| clk_sel | input | 4 | Count source select: 0..10 prescaler tap, 11 external, 12 timer, 13..15 none |
| divisor | input | 8 | Terminal count (0..3 handled as 4) |
| ext_clk | input | 1 | External clock, asynchronous |
| tmr_clk | input | 1 | Timer output, asynchronous |
| baud_clk | output | 1 | Baud clock, one toggle per match |
| match_tick | output | 1 | One-cycle pulse at each match |
| div_fault | output | 1 | Divisor below 4 was clamped |

## Verification
- **Toggle timing**: baud_clk and match_tick change one clock edge after the count enable that completes a count. The bench therefore samples every output at the falling edge and measures high times and periods as whole numbers of falling edges between transitions.
- **Restart timing**: after an enable is raised at a falling edge, the first rise is due at falling edge D·2^n+1. That count covers one edge for the state register plus D·2^n edges of counting.
- **External and timer sources**: these add a fixed three-edge synchronizer latency. That latency cancels out of any period measurement, so the bench measures only rise-to-rise intervals for these sources.
- **Clamp flag**: div_fault is combinational, so it is checked in the same cycle the divisor is applied.

// File: rtl/baud_pkg.sv
package baud_pkg;
    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } gen_state_t;

    localparam int SEL_W    = 4;
    localparam int NTAP     = 11;
    localparam int EXT_CODE = 11;
    localparam int TMR_CODE = 12;
    localparam int DIV_W    = 8;
    localparam int DIV_MIN  = 4;
endpackage

// File: rtl/baud_edge_sync.sv
module baud_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= async_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise_pulse = s2 & ~s3;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse); // R6
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
#(
    parameter int TAPS = NTAP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_pulse,
    input  logic             tmr_pulse,
    output logic             cnt_en
);
    localparam int PSC_W  = TAPS - 1;
    localparam int NCODES = 1 << SEL_W;

    logic [PSC_W-1:0]  psc;
    logic [NCODES-1:0] tap_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            psc <= '0;
        else if (!run)
            psc <= '0;
        else
            psc <= psc + 1'b1;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NCODES; gi++) begin : g_tap
            if (gi == 0) begin : g_t0
                assign tap_en[gi] = run;
            end else if (gi < TAPS) begin : g_tn
                assign tap_en[gi] = run & (&psc[gi-1:0]);
            end else begin : g_pad
                assign tap_en[gi] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        if (int'(sel) < TAPS)
            cnt_en = tap_en[sel];
        else if (int'(sel) == EXT_CODE)
            cnt_en = run & ext_pulse;
        else if (int'(sel) == TMR_CODE)
            cnt_en = run & tmr_pulse;
        else
            cnt_en = 1'b0;
    end

    AST_OFF_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !cnt_en); // R5
endmodule

// File: rtl/baud_match_ctr.sv
module baud_match_ctr
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cnt_en,
    input  logic [DIV_W-1:0] div_eff,
    output logic             tick,
    output logic             baud
);
    logic [DIV_W-1:0] cnt;
    logic             hit;

    assign hit = (cnt >= div_eff - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
            baud <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            tick <= 1'b0;
            baud <= 1'b0;
        end else if (cnt_en) begin
            if (hit) begin
                cnt  <= '0;
                tick <= 1'b1;
                baud <= ~baud;
            end else begin
                cnt  <= cnt + 1'b1;
                tick <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
    AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (baud != $past(baud))); // R4
    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_en) |=> ($stable(cnt) && $stable(baud))); // R8
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0 && !baud && !tick)); // R5
endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_en,
    input  logic             dir_en,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic [DIV_W-1:0] divisor,
    input  logic             ext_clk,
    input  logic             tmr_clk,
    output logic             baud_clk,
    output logic             match_tick,
    output logic             div_fault
);
    gen_state_t       state, state_nx;
    logic             run;
    logic             ext_pulse, tmr_pulse, cnt_en;
    logic [DIV_W-1:0] div_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        run      = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (pwr_en && dir_en)
                    state_nx = ST_RUN;          // GO
            end
            ST_RUN: begin
                run = 1'b1;
                if (!pwr_en || !dir_en)
                    state_nx = ST_OFF;          // STOP
            end
            default: state_nx = ST_OFF;
        endcase
    end

    assign div_fault = (divisor < DIV_W'(DIV_MIN));
    assign div_eff   = div_fault ? DIV_W'(DIV_MIN) : divisor;

    baud_edge_sync u_ext_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (ext_clk),
        .rise_pulse(ext_pulse)
    );

    baud_edge_sync u_tmr_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (tmr_clk),
        .rise_pulse(tmr_pulse)
    );

    baud_prescaler #(.TAPS(NTAP)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sel      (clk_sel),
        .ext_pulse(ext_pulse),
        .tmr_pulse(tmr_pulse),
        .cnt_en   (cnt_en)
    );

    baud_match_ctr u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .cnt_en (cnt_en),
        .div_eff(div_eff),
        .tick   (match_tick),
        .baud   (baud_clk)
    );

    AST_STOP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en || !dir_en) |=> (state == ST_OFF)); // R5
    AST_FAULT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        div_fault |-> (u_ctr.div_eff == DIV_W'(DIV_MIN))); // R3
endmodule

// File: tb/baud_gen_test.sv
module baud_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_en = 1'b0, dir_en = 1'b0;
    logic [3:0] clk_sel = '0;
    logic [7:0] divisor = 8'd4;
    logic       ext_clk = 1'b0, tmr_clk = 1'b0;
    logic       baud_clk, match_tick, div_fault;

    int errors = 0;
    int checks = 0;
    int ext_half = 0, tmr_half = 0;
    int ext_cnt = 0, tmr_cnt = 0;

    always #5 clk = ~clk;

    baud_gen uut (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .dir_en(dir_en),
        .clk_sel(clk_sel), .divisor(divisor), .ext_clk(ext_clk),
        .tmr_clk(tmr_clk), .baud_clk(baud_clk), .match_tick(match_tick),
        .div_fault(div_fault)
    );

    always @(negedge clk) begin
        if (ext_half > 0) begin
            ext_cnt = ext_cnt + 1;
            if (ext_cnt >= ext_half) begin ext_cnt = 0; ext_clk = ~ext_clk; end
        end
        if (tmr_half > 0) begin
            tmr_cnt = tmr_cnt + 1;
            if (tmr_cnt >= tmr_half) begin tmr_cnt = 0; tmr_clk = ~tmr_clk; end
        end
    end

    function automatic int eff_div(input int d);
        return (d < 4) ? 4 : d;
    endfunction

    function automatic int tap_period(input int n);
        return 1 << n;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_level(input logic lvl, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (baud_clk == lvl) begin ok = 1'b1; break; end
        end
    endtask

    task automatic measure(input string tag, input int unit, input int d);
        bit ok;
        int hi, per, ticks;
        wait_level(1'b0, ok);
        if (ok) wait_level(1'b1, ok);
        hi = 0; per = 0; ticks = 0;
        if (ok) begin
            while (baud_clk == 1'b1 && per < 40000) begin
                @(negedge clk); hi++; per++;
                if (match_tick) ticks++;
            end
            while (baud_clk == 1'b0 && per < 40000) begin
                @(negedge clk); per++;
                if (match_tick) ticks++;
            end
        end
        check({tag, " high"}, hi, eff_div(d) * unit);
        check({tag, " period"}, per, 2 * eff_div(d) * unit);
        check({tag, " R4 ticks/period"}, ticks, 2);
    endtask

    task automatic setup(input int sel, input int d);
        @(negedge clk);
        pwr_en = 1'b0;
        @(negedge clk);
        clk_sel = 4'(sel);
        divisor = 8'(d);
        pwr_en = 1'b1;
        dir_en = 1'b1;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int n, d, cyc;
        logic b0;
        process::self().srandom(32'h5eed);
        repeat (3) @(negedge clk);
        check("R1 baud after reset", int'(baud_clk), 0);
        check("R1 tick after reset", int'(match_tick), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 off while disabled", int'(baud_clk), 0);

        // R2 directed taps
        setup(0, 4);   measure("R2 sel0 d4", 1, 4);
        setup(0, 255); measure("R2 sel0 d255", 1, 255);
        setup(10, 4);  measure("R2 sel10 d4", tap_period(10), 4);
        // R2 random
        for (int k = 0; k < 8; k++) begin
            n = $urandom_range(0, 4);
            d = $urandom_range(4, 40);
            setup(n, d);
            measure($sformatf("R2 rnd sel%0d d%0d", n, d), tap_period(n), d);
        end

        // R3 clamp
        for (int dv = 0; dv < 4; dv++) begin
            setup(1, dv);
            @(negedge clk);
            check($sformatf("R3 fault d%0d", dv), int'(div_fault), 1);
            measure($sformatf("R3 clamp d%0d", dv), 2, dv);
        end
        setup(0, 4);
        @(negedge clk);
        check("R3 no fault d4", int'(div_fault), 0);

        // R5 stop and deterministic restart
        setup(1, 4);
        repeat (37) @(negedge clk);
        dir_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 baud low when dir off", int'(baud_clk), 0);
        check("R5 tick low when dir off", int'(match_tick), 0);
        dir_en = 1'b1;
        cyc = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); cyc++;
            if (baud_clk) break;
        end
        check("R5 first rise edges", cyc, 4 * 2 + 1);

        // R6 external clock, period 6
        ext_half = 3;
        setup(11, 5); measure("R6 ext P6 d5", 6, 5);
        ext_half = 0;
        // R7 timer output, period 10
        tmr_half = 5;
        setup(12, 4); measure("R7 tmr P10 d4", 10, 4);

        // R8 no-clock codes hold
        for (int c = 13; c < 16; c++) begin
            ext_half = 2; tmr_half = 2;
            setup(0, 4);
            repeat (6) @(negedge clk);
            clk_sel = 4'(c);
            @(negedge clk);
            b0 = baud_clk;
            cyc = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (baud_clk != b0 || match_tick) cyc++;
            end
            check($sformatf("R8 hold code%0d", c), cyc, 0);
        end
        ext_half = 0; tmr_half = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule